// File: doc/BRIEF.md
# Core Prioritized Event Controller

This block arbitrates between sixteen event request lines of fixed priority and tells the processor core which event to service next. Level 0 is the most urgent and level 15 the least. The levels are assigned by class: 0 debug/emulation, 1 reset, 2 non-maskable interrupt, 3 exception, 4 unused, 5 hardware error, 6 core timer, and 7 to 15 general-purpose interrupts. Levels 14 and 15 are intended for software-raised interrupts, which leaves 7 to 13 for peripherals. A separate system-level mapping block drives the general-purpose request lines.

A rising edge on a request line sets that level's bit in a 16-bit pending register. A 16-bit enable register gates levels 5 to 15, and a 16-bit in-service register records which accepted events are still being handled. The block presents the highest-priority eligible pending level, with a valid flag. The core confirms it with an acknowledge pulse and later closes it with a return pulse. Software can cancel pending events by writing ones to a clear port. The non-maskable level can be raised by its own request line, by an external pin, or by a watchdog timeout.

Top module: `core_event_ctrl`

## Requirements
- R1: After synchronous reset, the pending, enable and in-service registers all read 0 and `evt_valid_o` is 0.
- R2: A pending bit is set on the cycle after its request goes from 0 to 1; the reset clears the previous sample, so a line already high as reset releases counts as a rise. A request held high does not set the bit again until it has dropped and risen. Level 2 rises on the OR of `req_i[2]`, `nmi_pin_i` and `wdog_i`.
- R3: Level 4 never becomes pending and is never presented.
- R4: Among eligible pending levels, the lowest index is presented on `evt_idx_o` (4-bit binary level number).
- R5: Levels 0 to 3 are presented whatever the enable register holds. Levels 5 to 15 still latch while disabled, but are presented only while their enable bit is 1.
- R6: A pulse on `clr_wr_i` clears every pending bit where `clr_data_i` is 1 on the next cycle. A rising request in that same cycle wins, and its bit stays set.
- R7: `ack_i` while `evt_valid_o` is 1 clears the presented level's pending bit and sets its in-service bit on the next cycle. `ack_i` while `evt_valid_o` is 0 changes nothing.
- R8: A level is presented only if its index is strictly lower than that of every set in-service bit.
- R9: `rfe_i` clears the lowest-indexed set in-service bit, and arbitration for lower levels resumes on the following cycle.
- R10: A pulse on `en_wr_i` loads all 16 bits of `en_data_i` into the enable register on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 16 | Request lines, one per level, sampled for rising edges |
| nmi_pin_i | input | 1 | External non-maskable request, joins level 2 |
| wdog_i | input | 1 | Watchdog timeout request, joins level 2 |
| en_wr_i | input | 1 | Load the enable register |
| en_data_i | input | 16 | New enable value |
| clr_wr_i | input | 1 | Cancel pending events |
| clr_data_i | input | 16 | Write-one-to-clear mask for the pending register |
| ack_i | input | 1 | Core accepts the presented event |
| rfe_i | input | 1 | Core returns from the innermost event |
| evt_valid_o | output | 1 | An event is presented |
| evt_idx_o | output | 4 | Level number of the presented event |
| pend_o | output | 16 | Pending register |
| en_o | output | 16 | Enable register |
| insvc_o | output | 16 | In-service register |

## Verification
The arbiter is tried with single requests, with simultaneous rises on several levels, and with requests that arrive while a level is in service. Simultaneous rises show whether the lowest index wins. Requests at a level below, equal to and above the one in service show whether strict nesting holds. Disabling a general-purpose level while an unmaskable one is pending shows whether the gate applies only to levels 5 and up. Held-high, re-raised and cancelled requests show edge capture and cancellation apart, including a rise that lands in the same cycle as its own cancel.

// File: rtl/cec_pkg.sv
package cec_pkg;
    localparam int NUM_LVL  = 16;
    localparam int IDX_W    = $clog2(NUM_LVL);
    localparam int LVL_NMI  = 2;
    localparam int LVL_RSVD = 4;
    localparam int NUM_FIXED_ON = 4;  // levels 0..3 ignore the enable register

    typedef logic [NUM_LVL-1:0] lvl_vec_t;
    typedef logic [IDX_W-1:0]   lvl_idx_t;

    typedef enum logic [IDX_W-1:0] {
        CLS_DEBUG = 4'd0, CLS_RESET = 4'd1, CLS_NMI = 4'd2, CLS_EXCEPT = 4'd3,
        CLS_UNUSED = 4'd4, CLS_HWERR = 4'd5, CLS_TIMER = 4'd6, CLS_GP_FIRST = 4'd7
    } evt_class_e;

    typedef struct packed {
        logic     found;
        lvl_idx_t idx;
    } pick_t;

    localparam lvl_vec_t ALWAYS_ON = lvl_vec_t'((1 << NUM_FIXED_ON) - 1);
    localparam lvl_vec_t RSVD_MASK = lvl_vec_t'(1) << LVL_RSVD;

    function automatic pick_t lowest_set(input lvl_vec_t v);
        pick_t r;
        r.found = 1'b0;
        r.idx   = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.found = 1'b1;
                r.idx   = lvl_idx_t'(i);
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/cec_edge_detect.sv
module cec_edge_detect
    import cec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t lines_i,
    output lvl_vec_t rise_o
);
    lvl_vec_t prev_q;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) prev_q[g] <= 1'b0;
            else     prev_q[g] <= lines_i[g];
        end
        assign rise_o[g] = lines_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/cec_arbiter.sv
module cec_arbiter
    import cec_pkg::*;
(
    input  lvl_vec_t pend_i,
    input  lvl_vec_t en_i,
    input  lvl_vec_t insvc_i,
    output logic     valid_o,
    output lvl_idx_t idx_o
);
    lvl_vec_t eligible;
    pick_t    winner;
    pick_t    busy;

    always_comb begin
        eligible = pend_i & (en_i | ALWAYS_ON) & ~RSVD_MASK;
        winner   = lowest_set(eligible);
        busy     = lowest_set(insvc_i);
        valid_o  = winner.found && (!busy.found || (winner.idx < busy.idx));
        idx_o    = winner.idx;
    end
endmodule

// File: rtl/cec_insvc_tracker.sv
module cec_insvc_tracker
    import cec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ack_fire_i,
    input  lvl_idx_t ack_idx_i,
    input  logic     rfe_i,
    output lvl_vec_t insvc_o
);
    lvl_vec_t insvc_q;
    lvl_vec_t after_rfe;

    always_comb begin
        // clearing the lowest set bit retires the innermost (highest-priority) event
        after_rfe = rfe_i ? (insvc_q & (insvc_q - lvl_vec_t'(1))) : insvc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) insvc_q <= '0;
        else if (ack_fire_i) insvc_q <= after_rfe | (lvl_vec_t'(1) << ack_idx_i);
        else insvc_q <= after_rfe;
    end

    assign insvc_o = insvc_q;

    assert_ack_marks_R7: assert property (@(posedge clk) disable iff (rst)
        ack_fire_i |=> insvc_q[$past(ack_idx_i)]);

    assert_rfe_retires_one_R9: assert property (@(posedge clk) disable iff (rst)
        (rfe_i && !ack_fire_i && insvc_q != '0)
        |=> ($countones(insvc_q) == $countones($past(insvc_q)) - 1));
endmodule

// File: rtl/core_event_ctrl.sv
module core_event_ctrl
    import cec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] req_i,
    input  logic        nmi_pin_i,
    input  logic        wdog_i,
    input  logic        en_wr_i,
    input  logic [15:0] en_data_i,
    input  logic        clr_wr_i,
    input  logic [15:0] clr_data_i,
    input  logic        ack_i,
    input  logic        rfe_i,
    output logic        evt_valid_o,
    output logic [3:0]  evt_idx_o,
    output logic [15:0] pend_o,
    output logic [15:0] en_o,
    output logic [15:0] insvc_o
);
    lvl_vec_t lines, rise, pend_q, en_q, insvc, ack_vec, clr_vec;
    logic     valid, ack_fire;
    lvl_idx_t idx;

    always_comb begin
        lines          = req_i;
        lines[LVL_NMI] = req_i[LVL_NMI] | nmi_pin_i | wdog_i;
    end

    cec_edge_detect u_edge (
        .clk(clk), .rst(rst), .lines_i(lines), .rise_o(rise)
    );

    cec_arbiter u_arb (
        .pend_i(pend_q), .en_i(en_q), .insvc_i(insvc),
        .valid_o(valid), .idx_o(idx)
    );

    assign ack_fire = ack_i & valid;

    cec_insvc_tracker u_insvc (
        .clk(clk), .rst(rst), .ack_fire_i(ack_fire), .ack_idx_i(idx),
        .rfe_i(rfe_i), .insvc_o(insvc)
    );

    always_comb begin
        ack_vec = ack_fire ? (lvl_vec_t'(1) << idx) : '0;
        clr_vec = clr_wr_i ? clr_data_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec & ~ack_vec) | (rise & ~RSVD_MASK);
            if (en_wr_i) en_q <= en_data_i;
        end
    end

    assign evt_valid_o = valid;
    assign evt_idx_o   = idx;
    assign pend_o      = pend_q;
    assign en_o        = en_q;
    assign insvc_o     = insvc;

    assert_rsvd_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !pend_q[LVL_RSVD] && !(evt_valid_o && evt_idx_o == 4'(LVL_RSVD)));

    assert_set_needs_edge_R2: assert property (@(posedge clk) disable iff (rst)
        (pend_q & ~$past(pend_q) & ~$past(rise)) == '0);

    assert_presented_pending_R4: assert property (@(posedge clk) disable iff (rst)
        evt_valid_o |-> pend_q[evt_idx_o]);

    assert_strict_nesting_R8: assert property (@(posedge clk) disable iff (rst)
        evt_valid_o |-> ((insvc & ((lvl_vec_t'(2) << evt_idx_o) - lvl_vec_t'(1))) == '0));

    assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (evt_valid_o && evt_idx_o >= 4'(NUM_FIXED_ON)) |-> en_q[evt_idx_o]);
endmodule

// File: tb/core_event_ctrl_bench.sv
module core_event_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] req_i = '0;
    logic        nmi_pin_i = 1'b0, wdog_i = 1'b0;
    logic        en_wr_i = 1'b0, clr_wr_i = 1'b0, ack_i = 1'b0, rfe_i = 1'b0;
    logic [15:0] en_data_i = '0, clr_data_i = '0;
    logic        evt_valid_o;
    logic [3:0]  evt_idx_o;
    logic [15:0] pend_o, en_o, insvc_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    core_event_ctrl u_core_event_ctrl (
        .clk(clk), .rst(rst), .req_i(req_i), .nmi_pin_i(nmi_pin_i), .wdog_i(wdog_i),
        .en_wr_i(en_wr_i), .en_data_i(en_data_i), .clr_wr_i(clr_wr_i),
        .clr_data_i(clr_data_i), .ack_i(ack_i), .rfe_i(rfe_i),
        .evt_valid_o(evt_valid_o), .evt_idx_o(evt_idx_o), .pend_o(pend_o),
        .en_o(en_o), .insvc_o(insvc_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_idle(input string tag);
        check({tag, " valid"}, 32'(evt_valid_o), 32'd0);
    endtask

    task automatic expect_evt(input string tag, input int lvl);
        check({tag, " valid"}, 32'(evt_valid_o), 32'd1);
        check({tag, " idx"}, 32'(evt_idx_o), 32'(lvl));
    endtask

    task automatic write_en(input logic [15:0] v);
        en_wr_i = 1'b1; en_data_i = v; step(); en_wr_i = 1'b0;
    endtask

    task automatic cancel(input logic [15:0] v);
        clr_wr_i = 1'b1; clr_data_i = v; step(); clr_wr_i = 1'b0;
    endtask

    task automatic pulse_ack();
        ack_i = 1'b1; step(); ack_i = 1'b0;
    endtask

    task automatic pulse_rfe();
        rfe_i = 1'b1; step(); rfe_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pend", 32'(pend_o), 0);
        check("R1 en", 32'(en_o), 0);
        check("R1 insvc", 32'(insvc_o), 0);
        expect_idle("R1");
    endtask

    task automatic t_edge();
        write_en(16'hFFFF);
        check("R10 en load", 32'(en_o), 32'hFFFF);
        req_i[9] = 1'b1; step();
        check("R2 rise sets", 32'(pend_o), 32'h0200);
        expect_evt("R2 single", 9);
        pulse_ack();
        check("R7 pend cleared", 32'(pend_o), 0);
        check("R7 insvc set", 32'(insvc_o), 32'h0200);
        step(); step();
        check("R2 held no reset", 32'(pend_o), 0);
        pulse_rfe();
        check("R9 insvc cleared", 32'(insvc_o), 0);
        req_i[9] = 1'b0; step();
        req_i[9] = 1'b1; step();
        check("R2 re-rise", 32'(pend_o), 32'h0200);
        cancel(16'h0200);
        check("R6 cancel", 32'(pend_o), 0);
        expect_idle("R6 after cancel");
        req_i = '0; step();
    endtask

    task automatic t_reserved();
        req_i[4] = 1'b1; step();
        check("R3 level4 pend", 32'(pend_o), 0);
        expect_idle("R3 level4");
        req_i = '0; step();
    endtask

    task automatic t_priority();
        req_i[12] = 1'b1; req_i[6] = 1'b1; step();
        expect_evt("R4 pair", 6);
        nmi_pin_i = 1'b1; step();
        expect_evt("R2 nmi pin", 2);
        cancel(16'hFFFF);
        req_i = '0; nmi_pin_i = 1'b0; step();
        wdog_i = 1'b1; step();
        expect_evt("R2 watchdog", 2);
        cancel(16'hFFFF);
        wdog_i = 1'b0; step();
    endtask

    task automatic t_gate();
        write_en(16'h0000);
        req_i[3] = 1'b1; req_i[8] = 1'b1; step();
        check("R5 disabled still latches", 32'(pend_o), 32'h0108);
        expect_evt("R5 unmaskable", 3);
        cancel(16'h0008);
        expect_idle("R5 level8 gated");
        write_en(16'h0100);
        expect_evt("R5 level8 enabled", 8);
        cancel(16'hFFFF);
        req_i = '0; step();
    endtask

    task automatic t_nesting();
        write_en(16'hFFFF);
        req_i[10] = 1'b1; step();
        pulse_ack();
        check("R7 nest insvc", 32'(insvc_o), 32'h0400);
        req_i[12] = 1'b1; step();
        expect_idle("R8 lower blocked");
        req_i[10] = 1'b0; step();
        req_i[10] = 1'b1; step();
        expect_idle("R8 equal blocked");
        req_i[7] = 1'b1; step();
        expect_evt("R8 higher preempts", 7);
        pulse_ack();
        check("R8 two in service", 32'(insvc_o), 32'h0480);
        pulse_rfe();
        check("R9 innermost retired", 32'(insvc_o), 32'h0400);
        expect_idle("R9 still nested");
        pulse_rfe();
        check("R9 all retired", 32'(insvc_o), 0);
        expect_evt("R9 resume", 10);
        cancel(16'hFFFF);
        req_i = '0; step();
    endtask

    task automatic t_races();
        req_i[11] = 1'b1; clr_wr_i = 1'b1; clr_data_i = 16'h0800; step();
        clr_wr_i = 1'b0;
        check("R6 rise beats cancel", 32'(pend_o), 32'h0800);
        cancel(16'hFFFF);
        req_i = '0; step();
        pulse_ack();
        check("R7 idle ack insvc", 32'(insvc_o), 0);
        check("R7 idle ack pend", 32'(pend_o), 0);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_edge();
        t_reserved();
        t_priority();
        t_gate();
        t_nesting();
        t_races();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule